// File: doc/BRIEF.md
# Serial-Key Clock Register Gate

This block sits between a host bus and a ROM socket and observes every ROM access. While locked, it lets the ROM answer every access. It also reads one bit from the low address line A0 on each ordinary read that keeps A2 low, and compares the resulting stream against a fixed 64-bit key. When all 64 key bits arrive in order, the next 64 accesses go to a 64-bit clock register bank instead of the ROM. The ROM output enable is held off for those accesses, and each access moves one bit of the bank.

Inside that window, a read drives the selected bank bit onto D0. A write-type access loads a bit into the bank. A write-type access is either a read with A2 high, which supplies the bit on A0, or a real bus write with write enable low, which supplies the bit on D0. After the 64th window access the block locks itself again and matching starts from the first key bit. An external reset pin can discard a match in progress unless the bank's reset-enable bit is set.

An access begins when chip enable falls together with either output enable or write enable. The block samples the address lines on the system clock cycle in which that condition first appears. Its registered outputs change on the following clock edge.

Top module: `serial_clock_gate`

## Requirements
- R1: After reset the block is locked, `d0_oe` is 0 and `rom_oe_n` is 1 while no access is in progress; the first access is served by the ROM (`rom_oe_n` low, `d0_oe` low).
- R2: An access with A2 low, output enable low and write enable high is a key step whose bit is A0. Key bit k is bit (k mod 8) of byte k/8 of the sequence C5h, 3Ah, A3h, 5Ch, C5h, 3Ah, A3h, 5Ch, least significant bit first. Sending each byte most significant bit first does not unlock.
- R3: Until the full key has been matched, every access is served by the ROM and none changes the clock bank. This holds even for accesses with A2 high and for bus writes.
- R4: After a full match, exactly the next 64 accesses go to the bank, and `rom_oe_n` stays high throughout each of them.
- R5: Window access n (0 to 63) addresses bank bit n. An access with A2 high loads A0 into that bit. A bus write (write enable low) loads D0 into that bit.
- R6: After the 64th window access the block is locked again. The next access is served by the ROM, and a new unlock needs the whole key from its first bit.
- R7: A wrong key bit restarts matching, and that same bit is re-evaluated as a possible first key bit. A single 1 followed by the full key therefore unlocks, while a key with its last bit inverted does not.
- R8: During matching, an access with A2 high aborts the match in progress.
- R9: If `rst_pin_n` is low while bank bit 36 (reset enable) is 0, any match in progress is discarded. When bit 36 is 1, the pin has no effect on matching.
- R10: `d0_oe` is high only during read accesses inside the window, and `d0_out` then carries the addressed bank bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Active-low chip enable of the ROM socket |
| oe_n | input | 1 | Active-low output enable (read access) |
| we_n | input | 1 | Active-low write enable (bus write access) |
| a0 | input | 1 | Address bit 0: key bit or write data |
| a2 | input | 1 | Address bit 2: low for a key step or read, high for a write-type access |
| d0_in | input | 1 | Data bit 0 from the bus during a bus write |
| rst_pin_n | input | 1 | Active-low external reset pin that can discard a match |
| rom_oe_n | output | 1 | Active-low enable allowing the ROM to drive the bus |
| d0_out | output | 1 | Bank bit driven on data bit 0 |
| d0_oe | output | 1 | Drive enable for `d0_out` |

## Verification
Several 64-bit patterns, including all zeros, all ones, a single set bit at each end and a mixed word, are written through the window and read back. This separates correct bit addressing from shifted or reversed indexing. The key is tried exactly, with a one-bit prefix, with its last bit inverted, with bit order reversed inside each byte, and interrupted by an A2-high access. Together these distinguish proper restart and re-evaluation from a plain counter reset or a wrong bit order. Accesses with A2 high and bus writes made before unlock show that the bank is untouched while locked. The reset pin is pulsed mid-match with the enable bit clear and then set, which shows that its effect depends on the bank.

// File: rtl/scg_pkg.sv
package scg_pkg;
  localparam int KEY_BITS = 64;
  localparam int BANK_BITS = 64;
  localparam logic [KEY_BITS-1:0] KEY_VALUE = 64'h5CA3_3AC5_5CA3_3AC5;
  localparam int RSTEN_BIT = 36;
  localparam int CNT_W = $clog2(KEY_BITS) + 1;
  localparam int POS_W = $clog2(BANK_BITS) + 1;

  typedef struct packed {
    logic a0;
    logic a2;
    logic wr_bus;
    logic d_bus;
  } acc_t;
endpackage

// File: rtl/scg_reset_sync.sv
module scg_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/scg_access_detect.sv
module scg_access_detect
  import scg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic a0,
  input  logic a2,
  input  logic d0_in,
  output logic active,
  output logic strobe,
  output acc_t acc
);
  logic act_q, act_d;

  assign active = ~ce_n & (~oe_n | ~we_n);
  assign strobe = active & ~act_q;
  assign act_d  = active;

  assign acc.a0     = a0;
  assign acc.a2     = a2;
  assign acc.wr_bus = ~we_n;
  assign acc.d_bus  = d0_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  // One strobe per access, never on consecutive clocks.
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/scg_key_matcher.sv
module scg_key_matcher
  import scg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic step_a0,
  input  logic step_a2,
  input  logic step_wr,
  input  logic window_open,
  input  logic rst_pin_n,
  input  logic rsten,
  output logic unlock
);
  localparam int IDX_W = $clog2(KEY_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bit_ok;

  assign bit_ok = (step_a0 == KEY_VALUE[cnt_q[IDX_W-1:0]]);

  always_comb begin
    cnt_d  = cnt_q;
    unlock = 1'b0;
    if (!rst_pin_n && !rsten) begin
      cnt_d = '0;
    end else if (strobe && !window_open) begin
      if (step_a2 || step_wr) begin
        cnt_d = '0;
      end else if (bit_ok) begin
        if (cnt_q == LAST) begin
          cnt_d  = '0;
          unlock = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = (step_a0 == KEY_VALUE[0]) ? CNT_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !window_open && step_a2) |=> (cnt_q == '0));
  p_rstpin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pin_n && !rsten) |=> (cnt_q == '0));
  p_unlock_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    window_open |-> !unlock);
endmodule

// File: rtl/scg_clock_window.sv
module scg_clock_window
  import scg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic active,
  input  acc_t acc,
  input  logic unlock,
  output logic window_open,
  output logic rsten,
  output logic rom_oe_n,
  output logic d0_out,
  output logic d0_oe
);
  localparam int IDX_W = $clog2(BANK_BITS);
  localparam logic [POS_W-1:0] LAST = POS_W'(BANK_BITS - 1);

  logic                 win_q, win_d;
  logic [POS_W-1:0]     pos_q, pos_d;
  logic                 drv_q, drv_d;
  logic                 dat_q, dat_d;
  logic                 rom_q, rom_d;
  logic [BANK_BITS-1:0] bank_q;
  logic                 wr_cyc, wdata, wr_en;

  assign wr_cyc = acc.a2 | acc.wr_bus;
  assign wdata  = acc.wr_bus ? acc.d_bus : acc.a0;
  assign wr_en  = strobe & win_q & wr_cyc;

  always_comb begin
    win_d = win_q;
    pos_d = pos_q;
    if (unlock) begin
      win_d = 1'b1;
      pos_d = '0;
    end else if (strobe && win_q) begin
      if (pos_q == LAST) begin
        win_d = 1'b0;
        pos_d = '0;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_comb begin
    drv_d = drv_q;
    dat_d = dat_q;
    rom_d = rom_q;
    if (strobe) begin
      drv_d = win_q & ~wr_cyc;
      dat_d = bank_q[pos_q[IDX_W-1:0]];
      rom_d = ~win_q;
    end else if (!active) begin
      drv_d = 1'b0;
      rom_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      pos_q <= '0;
      drv_q <= 1'b0;
      dat_q <= 1'b0;
      rom_q <= 1'b0;
    end else begin
      win_q <= win_d;
      pos_q <= pos_d;
      drv_q <= drv_d;
      dat_q <= dat_d;
      rom_q <= rom_d;
    end
  end

  for (genvar i = 0; i < BANK_BITS; i++) begin : g_bank
    logic hit;
    assign hit = wr_en && (pos_q[IDX_W-1:0] == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q[i] <= 1'b0;
      else if (hit) bank_q[i] <= wdata;
    end
  end

  assign window_open = win_q;
  assign rsten       = bank_q[RSTEN_BIT];
  assign rom_oe_n    = ~rom_q;
  assign d0_out      = dat_q;
  assign d0_oe       = drv_q;

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> !rom_q);
  p_rom_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_q) |-> $past(!win_q));
  p_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && strobe && pos_q == LAST) |=> !win_q);
  p_drive_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q) |-> $past(win_q));
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_q |=> $stable(bank_q));
endmodule

// File: rtl/serial_clock_gate.sv
module serial_clock_gate
  import scg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic a0,
  input  logic a2,
  input  logic d0_in,
  input  logic rst_pin_n,
  output logic rom_oe_n,
  output logic d0_out,
  output logic d0_oe
);
  logic rst_s_n, active, strobe, unlock, window_open, rsten;
  acc_t acc;

  scg_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  scg_access_detect u_det (
    .clk(clk), .rst_n(rst_s_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .a0(a0), .a2(a2), .d0_in(d0_in), .active(active), .strobe(strobe),
    .acc(acc)
  );

  scg_key_matcher u_key (
    .clk(clk), .rst_n(rst_s_n), .strobe(strobe), .step_a0(acc.a0),
    .step_a2(acc.a2), .step_wr(acc.wr_bus), .window_open(window_open),
    .rst_pin_n(rst_pin_n), .rsten(rsten), .unlock(unlock)
  );

  scg_clock_window u_win (
    .clk(clk), .rst_n(rst_s_n), .strobe(strobe), .active(active),
    .acc(acc), .unlock(unlock), .window_open(window_open), .rsten(rsten),
    .rom_oe_n(rom_oe_n), .d0_out(d0_out), .d0_oe(d0_oe)
  );
endmodule

// File: tb/serial_clock_gate_bench.sv
module serial_clock_gate_bench;
  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, a0, a2, d0_in, rst_pin_n;
  logic rom_oe_n, d0_out, d0_oe;
  int total = 0;
  int fails = 0;
  bit done = 0;

  localparam int RSTEN = 36;
  localparam logic [7:0] KB [8] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C,
                                   8'hC5, 8'h3A, 8'hA3, 8'h5C};
  typedef struct packed { logic [63:0] wr; logic [63:0] exp; } vec_t;
  localparam vec_t VECS [5] = '{
    '{64'h0, 64'h0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    '{64'hA5A5_0F0F_1234_8001, 64'hA5A5_0F0F_1234_8001},
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
    '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001}};

  always #5 clk = ~clk;

  serial_clock_gate u_serial_clock_gate (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .a0(a0), .a2(a2), .d0_in(d0_in), .rst_pin_n(rst_pin_n),
    .rom_oe_n(rom_oe_n), .d0_out(d0_out), .d0_oe(d0_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic key_bit(input int k);
    return KB[k/8][k%8];
  endfunction

  // One access; returns what the outputs showed during it.
  task automatic do_acc(input logic ia0, input logic ia2, input logic bus_wr,
                        input logic idat, output logic rom_on,
                        output logic drv, output logic dout);
    @(negedge clk);
    a0 = ia0; a2 = ia2; d0_in = idat; ce_n = 1'b0;
    if (bus_wr) we_n = 1'b0; else oe_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rom_on = ~rom_oe_n; drv = d0_oe; dout = d0_out;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic send_bits(input int from, input int upto, input bit msb_first);
    logic r, d, o;
    for (int k = from; k < upto; k++) begin
      logic b;
      b = msb_first ? KB[k/8][7 - k%8] : key_bit(k);
      do_acc(b, 1'b0, 1'b0, 1'b0, r, d, o);
    end
  endtask

  task automatic win_write(input logic [63:0] v, input bit bus, output int rom_cnt);
    logic r, d, o;
    rom_cnt = 0;
    for (int n = 0; n < 64; n++) begin
      if (bus) do_acc(1'b0, 1'b0, 1'b1, v[n], r, d, o);
      else     do_acc(v[n], 1'b1, 1'b0, 1'b0, r, d, o);
      if (r) rom_cnt++;
    end
  endtask

  task automatic win_read(output logic [63:0] v, output int rom_cnt, output int drv_cnt);
    logic r, d, o;
    rom_cnt = 0; drv_cnt = 0; v = '0;
    for (int n = 0; n < 64; n++) begin
      do_acc(1'b0, 1'b0, 1'b0, 1'b0, r, d, o);
      v[n] = o;
      if (r) rom_cnt++;
      if (d) drv_cnt++;
    end
  endtask

  // Probe: A2-high access outside the window is ROM-served and harmless.
  task automatic probe_locked(input string tag);
    logic r, d, o;
    do_acc(1'b0, 1'b1, 1'b0, 1'b0, r, d, o);
    check(r == 1'b1 && d == 1'b0, tag, {62'd0, r, d}, 64'd2);
  endtask

  task automatic pulse_rst_pin();
    @(negedge clk); rst_pin_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_pin_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int rc, wc, dc;
    logic r, d, o;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    a0 = 1'b0; a2 = 1'b0; d0_in = 1'b0; rst_pin_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: idle outputs after reset, first access goes to ROM
    check(d0_oe == 1'b0 && rom_oe_n == 1'b1, "R1 idle", {62'd0, d0_oe, rom_oe_n}, 64'd1);
    do_acc(1'b0, 1'b0, 1'b0, 1'b0, r, d, o);
    check(r == 1'b1 && d == 1'b0, "R1 first access", {62'd0, r, d}, 64'd2);

    // Table: write pattern through window, read it back (R4, R5, R6, R10)
    foreach (VECS[i]) begin
      send_bits(0, 64, 1'b0);
      win_write(VECS[i].wr, 1'b0, wc);
      check(wc == 0, "R4 rom off during writes", 64'(wc), 64'd0);
      send_bits(0, 64, 1'b0);
      win_read(v, rc, dc);
      check(v == VECS[i].exp, "R5 readback", v, VECS[i].exp);
      check(rc == 0, "R4 rom off during reads", 64'(rc), 64'd0);
      check(dc == 64, "R10 drive on reads", 64'(dc), 64'd64);
      probe_locked("R6 relocked after window");
    end

    // R5: bus writes with D0 data
    send_bits(0, 64, 1'b0);
    win_write(64'h0123_4567_89AB_CDEF, 1'b1, wc);
    check(wc == 0, "R4 rom off bus writes", 64'(wc), 64'd0);
    send_bits(0, 64, 1'b0);
    win_read(v, rc, dc);
    check(v == 64'h0123_4567_89AB_CDEF, "R5 bus write readback", v, 64'h0123_4567_89AB_CDEF);

    // R3: A2-high and bus-write accesses while locked leave the bank alone
    for (int n = 0; n < 64; n++) begin
      do_acc(1'b1, 1'b1, 1'b0, 1'b0, r, d, o);
      if (!r) check(1'b0, "R3 rom served", 64'(r), 64'd1);
      do_acc(1'b0, 1'b0, 1'b1, 1'b1, r, d, o);
      if (d) check(1'b0, "R10 no drive locked", 64'(d), 64'd0);
    end
    send_bits(0, 64, 1'b0);
    win_read(v, rc, dc);
    check(v == 64'h0123_4567_89AB_CDEF, "R3 bank untouched", v, 64'h0123_4567_89AB_CDEF);

    // R10: writes in window do not drive D0
    send_bits(0, 64, 1'b0);
    dc = 0;
    for (int n = 0; n < 64; n++) begin
      do_acc(1'b0, 1'b1, 1'b0, 1'b0, r, d, o);
      if (d) dc++;
    end
    check(dc == 0, "R10 no drive on writes", 64'(dc), 64'd0);

    // R2: bit-reversed byte order does not unlock
    send_bits(0, 64, 1'b1);
    probe_locked("R2 msb-first key rejected");

    // R7: leading 1 then full key unlocks
    do_acc(1'b1, 1'b0, 1'b0, 1'b0, r, d, o);
    send_bits(0, 64, 1'b0);
    win_read(v, rc, dc);
    check(rc == 0 && dc == 64, "R7 prefix then key unlocks", 64'(rc), 64'd0);
    // R7: last bit inverted does not unlock
    send_bits(0, 63, 1'b0);
    do_acc(~key_bit(63), 1'b0, 1'b0, 1'b0, r, d, o);
    probe_locked("R7 bad last bit rejected");

    // R8: A2-high access in the middle aborts
    send_bits(0, 32, 1'b0);
    do_acc(1'b0, 1'b1, 1'b0, 1'b0, r, d, o);
    send_bits(32, 64, 1'b0);
    probe_locked("R8 aborted match stays locked");

    // R9: bank bit 36 is 0 (last value written above has bit36=0)
    send_bits(0, 40, 1'b0);
    pulse_rst_pin();
    send_bits(40, 64, 1'b0);
    probe_locked("R9 reset pin discards match");
    // Set bit 36 and retry
    send_bits(0, 64, 1'b0);
    win_write(64'h0000_0010_0000_0000, 1'b0, wc);
    send_bits(0, 40, 1'b0);
    pulse_rst_pin();
    send_bits(40, 64, 1'b0);
    win_read(v, rc, dc);
    check(rc == 0 && v == 64'h0000_0010_0000_0000, "R9 pin ignored with enable set",
          v, 64'h0000_0010_0000_0000);
    probe_locked("R6 locked after final window");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule